// File: doc/BRIEF.md
# SPI Flash Memory-Mapped Read Controller

This block connects a simple request/response bus port to one serial flash device on a single-lane SPI link. A 32-bit control word, driven from outside the block, selects between two ways of working. In direct read mode the block runs a whole flash read for every bus read. It lowers chip select and can first send the enter-4-byte-address opcode. It then sends the configured read opcode and a 3- or 4-byte address. For the fast-read opcode it inserts dummy clocks. Finally it shifts in one to four data bytes and raises chip select again. Only after that does it report completion.

In user mode the bus drives the link byte by byte. Chip select follows a bit of the control word. Bus writes shift raw bytes out to the flash, and bus reads clock bytes in. The block watches the first byte written after each chip-select change and keeps it as the current command. When that command is the fast-read opcode, the next user-mode read first spends the configured dummy clocks and then collects its data. The remembered command is dropped once such a read has started, and also on every chip-select change.

The SPI clock uses mode 0 timing. It rests low, and each half period lasts a fixed number of system clocks set by a parameter.

Top module: `spi_flash_rd_ctrl`

## Requirements
- R1: After reset, `spi_cs_n` is high, `spi_sclk` is low, `req_ready` is high and `rsp_done` is low.
- R2: When `cfg_ctrl[1:0]` is not 3 (direct mode), a bus read produces one chip-select frame. The frame carries the opcode `cfg_ctrl[23:16]`, then a 3-byte address (most significant byte first), then the data bytes. `spi_cs_n` is already high in the cycle where `rsp_done` pulses.
- R3: When `cfg_ctrl[13]` is set, a direct read sends 0xB7 before the opcode and then sends all 4 address bytes, most significant first.
- R4: The dummy count is the 3-bit value {`cfg_ctrl[14]`, `cfg_ctrl[7:6]`}. Only when the active command is 0x0B, that count times 8 clock cycles are inserted before the data bytes, with MOSI held low. Any other command, or a count of zero, goes straight to data.
- R5: `req_size` gives the number of bytes minus one. Read bytes are packed little-endian into `rsp_rdata`, with the first received byte in bits 7:0 and unused upper bytes zero. MOSI is low while data is read.
- R6: SPI mode 0: SCLK rests low, each bit shifts out most significant first and is sampled on the rising edge, and one SCLK period lasts 2×`HALF_DIV` system clocks.
- R7: When `cfg_ctrl[1:0]` is 3 (user mode), `spi_cs_n` equals `cfg_ctrl[2]`. A write of N bytes shifts out `req_wdata` least significant byte first.
- R8: In user mode, the low byte of the first write after a chip-select change becomes the remembered command, and later writes do not replace it. A user read that starts with 0x0B remembered inserts the dummy cycles and then forgets the command, so the following read has none.
- R9: Any change of `cfg_ctrl[2]` clears the remembered command.
- R10: `rsp_done` is a one-cycle pulse, and `req_ready` is low from acceptance until after that pulse.
- R11: A bus write in direct mode completes with `rsp_done` and produces no chip-select or SCLK activity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ctrl | input | 32 | Control word: opcode, mode, dummy count, 4-byte flag, chip-select stop |
| req_valid | input | 1 | Bus request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Flash byte address for direct reads |
| req_size | input | SZ_W | Access size in bytes minus one |
| req_wdata | input | DATA_W | Write bytes, low byte sent first |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read result, valid with rsp_done |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |

## Verification
The bench sweeps direct reads over both address widths, both the plain and the fast opcode, every dummy count and every access size. This separates three things: the address width (is 0xB7 present, and are there three or four address bytes), the opcode gating of the dummy phase, and the byte packing of the result. A model flash returns a position-dependent byte stream, so any misplaced or missing byte shows up as wrong data. User-mode sequences vary the order of the written opcodes and chip-select toggles. These sequences tell apart a first-byte snoop from a last-byte one, clear-on-select from no clear, and forget-after-read from a sticky command. A direct-mode write confirms the link stays silent.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;

    localparam logic [7:0] OP_FAST_READ = 8'h0B;
    localparam logic [7:0] OP_ENTER_4B  = 8'hB7;
    localparam logic [1:0] MODE_USER    = 2'd3;

    // control word bit positions
    localparam int CTL_OP_LSB  = 16;
    localparam int CTL_DMY_HI  = 14;
    localparam int CTL_ADDR4   = 13;
    localparam int CTL_DMY_LO  = 6;
    localparam int CTL_CS_STOP = 2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_CSOFF,
        S_DONE
    } seq_state_e;

    typedef enum logic [2:0] {
        P_ENTER4B,
        P_OPCODE,
        P_ADDR,
        P_DUMMY,
        P_DATA,
        P_WRITE
    } seq_phase_e;

    function automatic logic [2:0] dummy_count(input logic [31:0] ctl);
        return {ctl[CTL_DMY_HI], ctl[CTL_DMY_LO+1], ctl[CTL_DMY_LO]};
    endfunction

endpackage

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             sclk;
        logic [7:0]       sh;
        logic [7:0]       rx;
        logic [2:0]       bits;
        logic [DIV_W-1:0] div;
    } eng_t;

    eng_t eng_q, eng_d;

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (!eng_q.busy) begin
            if (start) begin
                eng_d.busy = 1'b1;
                eng_d.sh   = tx_byte;
                eng_d.bits = 3'd0;
                eng_d.div  = '0;
                eng_d.sclk = 1'b0;
            end
        end else if (eng_q.div != DIV_LAST) begin
            eng_d.div = eng_q.div + 1'b1;
        end else begin
            eng_d.div = '0;
            if (!eng_q.sclk) begin
                // rising edge: sample the flash output
                eng_d.sclk = 1'b1;
                eng_d.rx   = {eng_q.rx[6:0], miso};
            end else begin
                // falling edge: present the next bit
                eng_d.sclk = 1'b0;
                eng_d.sh   = {eng_q.sh[6:0], 1'b0};
                eng_d.bits = eng_q.bits + 3'd1;
                if (eng_q.bits == 3'd7) begin
                    eng_d.busy = 1'b0;
                    eng_d.done = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign done    = eng_q.done;
    assign rx_byte = eng_q.rx;
    assign sclk    = eng_q.sclk;
    assign mosi    = eng_q.busy & eng_q.sh[7];

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 4,
    localparam int DATA_W    = 8 * DATA_BYTES,
    localparam int SZ_W      = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_ctrl,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              cs_n_direct,
    output logic              eng_start,
    output logic [7:0]        eng_tx,
    input  logic              eng_done,
    input  logic [7:0]        eng_rx
);

    localparam int CNT_W = (SZ_W + 2 > 4) ? SZ_W + 2 : 4;

    typedef struct packed {
        seq_state_e        st;
        seq_phase_e        ph;
        logic              cs_n;
        logic              cs_prev;
        logic [7:0]        cmd_snoop;
        logic [7:0]        act_cmd;
        logic              is4b;
        logic              direct;
        logic [2:0]        dmy;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  nbytes;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wbuf;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t seq_q, seq_d;

    logic unused_cfg;
    assign unused_cfg = ^{cfg_ctrl[31:24], cfg_ctrl[15], cfg_ctrl[12:8], cfg_ctrl[5:3]};

    always_comb begin
        logic [31:0]      a32;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] cnt_nx;
        logic [7:0]       snoop_now;
        logic             need_dmy;
        logic             user;

        seq_d  = seq_q;
        eng_tx = 8'h00;
        user   = (cfg_ctrl[1:0] == MODE_USER);

        // every chip-select update forgets the snooped command
        seq_d.cs_prev = cfg_ctrl[CTL_CS_STOP];
        if (cfg_ctrl[CTL_CS_STOP] != seq_q.cs_prev) seq_d.cmd_snoop = 8'h00;
        snoop_now = seq_d.cmd_snoop;

        // address bytes left-aligned so byte 0 is always the top byte
        a32 = 32'(seq_q.addr);
        if (!seq_q.is4b) a32 = {a32[23:0], 8'h00};

        case (seq_q.ph)
            P_ENTER4B: eng_tx = OP_ENTER_4B;
            P_OPCODE:  eng_tx = seq_q.act_cmd;
            P_ADDR: begin
                for (int i = 0; i < 4; i++)
                    if (seq_q.cnt == CNT_W'(i)) eng_tx = a32[31-8*i -: 8];
            end
            P_WRITE: begin
                for (int i = 0; i < DATA_BYTES; i++)
                    if (seq_q.cnt == CNT_W'(i)) eng_tx = seq_q.wbuf[8*i +: 8];
            end
            default:   eng_tx = 8'h00;
        endcase

        case (seq_q.ph)
            P_ENTER4B, P_OPCODE: len = CNT_W'(1);
            P_ADDR:              len = seq_q.is4b ? CNT_W'(4) : CNT_W'(3);
            P_DUMMY:             len = CNT_W'(seq_q.dmy);
            default:             len = seq_q.nbytes;
        endcase

        need_dmy = (seq_q.act_cmd == OP_FAST_READ) && (seq_q.dmy != 3'd0);
        cnt_nx   = seq_q.cnt + CNT_W'(1);

        case (seq_q.st)
            S_IDLE: begin
                if (req_valid) begin
                    seq_d.nbytes = CNT_W'(req_size) + CNT_W'(1);
                    seq_d.cnt    = '0;
                    seq_d.rdata  = '0;
                    seq_d.dmy    = dummy_count(cfg_ctrl);
                    seq_d.is4b   = cfg_ctrl[CTL_ADDR4];
                    seq_d.addr   = req_addr;
                    seq_d.wbuf   = req_wdata;
                    if (user) begin
                        seq_d.direct = 1'b0;
                        seq_d.st     = S_ISSUE;
                        if (req_write) begin
                            if (snoop_now == 8'h00) seq_d.cmd_snoop = req_wdata[7:0];
                            seq_d.ph = P_WRITE;
                        end else begin
                            seq_d.act_cmd   = snoop_now;
                            seq_d.cmd_snoop = 8'h00;
                            seq_d.ph = ((snoop_now == OP_FAST_READ) &&
                                        (dummy_count(cfg_ctrl) != 3'd0)) ? P_DUMMY : P_DATA;
                        end
                    end else if (req_write) begin
                        // writes through the direct window touch nothing
                        seq_d.st = S_DONE;
                    end else begin
                        seq_d.direct  = 1'b1;
                        seq_d.act_cmd = cfg_ctrl[CTL_OP_LSB +: 8];
                        seq_d.cs_n    = 1'b0;
                        seq_d.ph      = cfg_ctrl[CTL_ADDR4] ? P_ENTER4B : P_OPCODE;
                        seq_d.st      = S_ISSUE;
                    end
                end
            end
            S_ISSUE: seq_d.st = S_WAIT;
            S_WAIT: begin
                if (eng_done) begin
                    if (seq_q.ph == P_DATA) begin
                        for (int i = 0; i < DATA_BYTES; i++)
                            if (seq_q.cnt == CNT_W'(i)) seq_d.rdata[8*i +: 8] = eng_rx;
                    end
                    seq_d.cnt = cnt_nx;
                    seq_d.st  = S_ISSUE;
                    if (cnt_nx == len) begin
                        seq_d.cnt = '0;
                        case (seq_q.ph)
                            P_ENTER4B: seq_d.ph = P_OPCODE;
                            P_OPCODE:  seq_d.ph = P_ADDR;
                            P_ADDR:    seq_d.ph = need_dmy ? P_DUMMY : P_DATA;
                            P_DUMMY:   seq_d.ph = P_DATA;
                            P_DATA: begin
                                if (seq_q.direct) begin
                                    seq_d.cs_n = 1'b1;
                                    seq_d.st   = S_CSOFF;
                                end else begin
                                    seq_d.st = S_DONE;
                                end
                            end
                            default:   seq_d.st = S_DONE;
                        endcase
                    end
                end
            end
            S_CSOFF: seq_d.st = S_DONE;
            default: seq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q         <= '0;
            seq_q.st      <= S_IDLE;
            seq_q.ph      <= P_OPCODE;
            seq_q.cs_n    <= 1'b1;
            seq_q.cs_prev <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign req_ready   = (seq_q.st == S_IDLE);
    assign rsp_done    = (seq_q.st == S_DONE);
    assign rsp_rdata   = seq_q.rdata;
    assign cs_n_direct = seq_q.cs_n;
    assign eng_start   = (seq_q.st == S_ISSUE);

endmodule

// File: rtl/spi_flash_rd_ctrl.sv
module spi_flash_rd_ctrl
    import spi_flash_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_BYTES = 4,
    parameter int HALF_DIV   = 2,
    localparam int DATA_W    = 8 * DATA_BYTES,
    localparam int SZ_W      = $clog2(DATA_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [31:0]       cfg_ctrl,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SZ_W-1:0]   req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic       cs_n_direct;
    logic       eng_start;
    logic [7:0] eng_tx;
    logic       eng_done;
    logic [7:0] eng_rx;

    spi_flash_seq #(
        .ADDR_W     (ADDR_W),
        .DATA_BYTES (DATA_BYTES)
    ) i_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_ctrl    (cfg_ctrl),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_write   (req_write),
        .req_addr    (req_addr),
        .req_size    (req_size),
        .req_wdata   (req_wdata),
        .rsp_done    (rsp_done),
        .rsp_rdata   (rsp_rdata),
        .cs_n_direct (cs_n_direct),
        .eng_start   (eng_start),
        .eng_tx      (eng_tx),
        .eng_done    (eng_done),
        .eng_rx      (eng_rx)
    );

    spi_byte_engine #(
        .HALF_DIV (HALF_DIV)
    ) i_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (eng_start),
        .tx_byte (eng_tx),
        .miso    (spi_miso),
        .done    (eng_done),
        .rx_byte (eng_rx),
        .sclk    (spi_sclk),
        .mosi    (spi_mosi)
    );

    // user mode hands chip select to the control word
    assign spi_cs_n = (cfg_ctrl[1:0] == MODE_USER) ? cfg_ctrl[CTL_CS_STOP] : cs_n_direct;

endmodule

// File: rtl/spi_flash_chk.sv
module spi_flash_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic       req_ready,
    input logic       rsp_done,
    input logic       spi_cs_n,
    input logic       spi_sclk,
    input logic       spi_mosi
);

    // R10: completion is a single-cycle pulse
    a_r10_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    // R10: not accepting while a response is being signalled
    a_r10_done_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !req_ready);

    // R2: direct transfers release chip select before completing
    a_r2_deselect_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && mode != 2'd3) |-> spi_cs_n);

    // R11: an idle direct-mode block leaves the flash deselected
    a_r11_idle_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && mode != 2'd3) |-> spi_cs_n);

    // R6: the serial clock rests low whenever the block is idle
    a_r6_sclk_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !spi_sclk);

    // R6: mode 0, data does not move while the clock is high
    a_r6_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

endmodule

bind spi_flash_rd_ctrl spi_flash_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (cfg_ctrl[1:0]),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .spi_cs_n  (spi_cs_n),
    .spi_sclk  (spi_sclk),
    .spi_mosi  (spi_mosi)
);

// File: tb/test_spi_flash_rd_ctrl.sv
module test_spi_flash_rd_ctrl;

    localparam int HALF = 2;
    localparam int WDOG = 190000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] cfg_ctrl;
    logic        req_valid;
    logic        req_ready;
    logic        req_write;
    logic [31:0] req_addr;
    logic [1:0]  req_size;
    logic [31:0] req_wdata;
    logic        rsp_done;
    logic [31:0] rsp_rdata;
    logic        spi_cs_n;
    logic        spi_sclk;
    logic        spi_mosi;
    logic        spi_miso;

    always #5 clk = ~clk;

    spi_flash_rd_ctrl #(.HALF_DIV(HALF)) i_spi_flash_rd_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_ctrl  (cfg_ctrl),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_size  (req_size),
        .req_wdata (req_wdata),
        .rsp_done  (rsp_done),
        .rsp_rdata (rsp_rdata),
        .spi_cs_n  (spi_cs_n),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso)
    );

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit ended  = 0;

    // ---------------- flash model / link monitor ----------------
    logic [7:0] mon_bytes [0:31];
    logic [7:0] mon_sh;
    int         mon_bits;
    int         cs_falls;
    time        t_r0, t_r1;

    function automatic logic [7:0] pat(input int k);
        return 8'((k * 59 + 92) ^ 60);
    endfunction

    function automatic logic pat_bit(input int b);
        logic [7:0] v;
        v = pat(b / 8);
        return v[3'(7 - (b % 8))];
    endfunction

    assign spi_miso = pat_bit(mon_bits);

    always @(posedge spi_sclk) begin
        logic [7:0] nb;
        nb     = {mon_sh[6:0], spi_mosi};
        mon_sh = nb;
        if (mon_bits % 8 == 7 && mon_bits / 8 < 32) mon_bytes[mon_bits / 8] = nb;
        if (mon_bits == 0) t_r0 = $time;
        if (mon_bits == 1) t_r1 = $time;
        mon_bits = mon_bits + 1;
    end

    always @(negedge spi_cs_n) cs_falls = cs_falls + 1;

    task automatic clr_mon();
        mon_bits = 0;
        cs_falls = 0;
        mon_sh   = 8'h00;
    endtask

    // ---------------- checking ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk = n_chk + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (cyc > WDOG && !ended) begin
            chk(1'b0, "WDOG", "watchdog expired", 64'(cyc), 64'(WDOG));
            finish_run();
        end
    end

    // one bus transaction; returns data, chip-select state at done, ready-while-busy
    task automatic do_req(input bit w, input logic [31:0] a, input logic [1:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd,
                          output logic cs_at_done, output logic rdy_busy,
                          output logic done_after);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = a;
        req_size  = sz;
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        rdy_busy  = req_ready;
        while (!rsp_done) @(negedge clk);
        rd         = rsp_rdata;
        cs_at_done = spi_cs_n;
        @(negedge clk);
        done_after = rsp_done;
    endtask

    function automatic logic [31:0] mk_ctrl(input logic [7:0] op, input logic [1:0] mode,
                                            input bit a4, input logic [2:0] dmy,
                                            input bit cs_stop);
        logic [31:0] c;
        c        = 32'h0;
        c[23:16] = op;
        c[14]    = dmy[2];
        c[13]    = a4;
        c[7:6]   = dmy[1:0];
        c[2]     = cs_stop;
        c[1:0]   = mode;
        return c;
    endfunction

    initial begin
        logic [31:0] rd;
        logic        csd, rb, da;
        logic [7:0]  exp_b [0:31];
        int          n_exp, d_start, it;
        logic [31:0] exp_rd;
        bit          same;
        logic [31:0] a;
        logic [7:0]  op;

        rst_n     = 1'b0;
        cfg_ctrl  = 32'h0;
        req_valid = 1'b0;
        req_write = 1'b0;
        req_addr  = 32'h0;
        req_size  = 2'd0;
        req_wdata = 32'h0;
        clr_mon();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(spi_cs_n == 1'b1, "R1", "cs_n after reset", 64'(spi_cs_n), 64'(1));
        chk(spi_sclk == 1'b0, "R1", "sclk after reset", 64'(spi_sclk), 64'(0));
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'(1));
        chk(rsp_done == 1'b0, "R1", "done after reset", 64'(rsp_done), 64'(0));

        // direct-mode sweep: address width x opcode x dummy count x size
        it = 0;
        for (int f = 0; f < 2; f++) begin
            for (int o = 0; o < 2; o++) begin
                for (int dm = 0; dm < 8; dm++) begin
                    for (int sz = 0; sz < 4; sz++) begin
                        op = (o != 0) ? 8'h0B : 8'h03;
                        a  = 32'h1A2B3C4D + 32'(it * 32'h01030507);
                        cfg_ctrl = mk_ctrl(op, (o != 0) ? 2'd1 : 2'd0, f != 0, 3'(dm), 1'b1);
                        clr_mon();
                        do_req(1'b0, a, 2'(sz), 32'h0, rd, csd, rb, da);

                        n_exp = 0;
                        if (f != 0) begin exp_b[n_exp] = 8'hB7; n_exp++; end
                        exp_b[n_exp] = op; n_exp++;
                        if (f != 0) begin exp_b[n_exp] = a[31:24]; n_exp++; end
                        exp_b[n_exp] = a[23:16]; n_exp++;
                        exp_b[n_exp] = a[15:8];  n_exp++;
                        exp_b[n_exp] = a[7:0];   n_exp++;
                        if (o != 0) begin
                            for (int k = 0; k < dm; k++) begin exp_b[n_exp] = 8'h00; n_exp++; end
                        end
                        d_start = n_exp;
                        exp_rd  = 32'h0;
                        for (int k = 0; k <= sz; k++) begin
                            exp_b[n_exp] = 8'h00; n_exp++;
                            exp_rd[8*k +: 8] = pat(d_start + k);
                        end

                        // R2/R3/R4: frame length
                        chk(mon_bits == n_exp * 8, (f != 0) ? "R3" : ((o != 0) ? "R4" : "R2"),
                            "sclk rising edges", 64'(mon_bits), 64'(n_exp * 8));
                        same = 1;
                        for (int k = 0; k < n_exp; k++) if (mon_bytes[k] !== exp_b[k]) same = 0;
                        // R2/R3/R4/R5: every byte on MOSI, including low dummy and data bytes
                        chk(same, (f != 0) ? "R3" : ((o != 0) ? "R4" : "R2"),
                            "mosi byte stream", 64'(mon_bytes[n_exp-1]), 64'(exp_b[n_exp-1]));
                        chk(rd == exp_rd, "R5", "read data packing", 64'(rd), 64'(exp_rd));
                        chk(csd == 1'b1 && cs_falls == 1, "R2", "one frame, deselected at done",
                            64'({csd, 8'(cs_falls)}), 64'({1'b1, 8'd1}));
                        chk(rb == 1'b0 && da == 1'b0, "R10", "busy not ready, done one cycle",
                            64'({rb, da}), 64'(0));
                        if (it == 0)
                            chk(t_r1 - t_r0 == time'(2 * HALF * 10), "R6", "sclk period",
                                64'(t_r1 - t_r0), 64'(2 * HALF * 10));
                        it++;
                    end
                end
            end
        end

        // R11: write in direct mode stays off the link
        cfg_ctrl = mk_ctrl(8'h03, 2'd0, 1'b0, 3'd0, 1'b0);
        clr_mon();
        do_req(1'b1, 32'h0, 2'd3, 32'hDEADBEEF, rd, csd, rb, da);
        chk(mon_bits == 0 && cs_falls == 0, "R11", "no link activity",
            64'({8'(mon_bits), 8'(cs_falls)}), 64'(0));

        // R7: chip select follows the control word in user mode
        cfg_ctrl = mk_ctrl(8'h00, 2'd3, 1'b0, 3'd2, 1'b1);
        @(negedge clk);
        chk(spi_cs_n == 1'b1, "R7", "user cs high", 64'(spi_cs_n), 64'(1));
        cfg_ctrl = mk_ctrl(8'h00, 2'd3, 1'b0, 3'd2, 1'b0);
        @(negedge clk);
        chk(spi_cs_n == 1'b0, "R7", "user cs low", 64'(spi_cs_n), 64'(0));

        // R7/R8: raw write, low byte first; first byte 0x0B is snooped
        clr_mon();
        do_req(1'b1, 32'h0, 2'd3, 32'h0302010B, rd, csd, rb, da);
        chk(mon_bits == 32 && mon_bytes[0] == 8'h0B && mon_bytes[1] == 8'h01 &&
            mon_bytes[2] == 8'h02 && mon_bytes[3] == 8'h03, "R7", "user write byte order",
            64'({mon_bytes[0], mon_bytes[1], mon_bytes[2], mon_bytes[3]}), 64'(32'h0B010203));
        clr_mon();
        do_req(1'b1, 32'h0, 2'd0, 32'h00000003, rd, csd, rb, da);
        chk(mon_bits == 8 && mon_bytes[0] == 8'h03, "R7", "single byte write",
            64'(mon_bytes[0]), 64'(8'h03));
        // R8: remembered 0x0B -> two dummy bytes, then two data bytes
        clr_mon();
        do_req(1'b0, 32'h0, 2'd1, 32'h0, rd, csd, rb, da);
        chk(mon_bits == 32, "R8", "dummy before user read", 64'(mon_bits), 64'(32));
        exp_rd = {16'h0, pat(3), pat(2)};
        chk(rd == exp_rd, "R8", "user read data after dummy", 64'(rd), 64'(exp_rd));
        // R8: forgotten after the read
        clr_mon();
        do_req(1'b0, 32'h0, 2'd0, 32'h0, rd, csd, rb, da);
        chk(mon_bits == 8, "R8", "no dummy on second read", 64'(mon_bits), 64'(8));
        chk(rd == {24'h0, pat(0)}, "R5", "single byte read", 64'(rd), 64'({24'h0, pat(0)}));

        // R9: chip-select change clears the snooped command
        do_req(1'b1, 32'h0, 2'd0, 32'h0000000B, rd, csd, rb, da);
        cfg_ctrl = mk_ctrl(8'h00, 2'd3, 1'b0, 3'd2, 1'b1);
        repeat (2) @(negedge clk);
        cfg_ctrl = mk_ctrl(8'h00, 2'd3, 1'b0, 3'd2, 1'b0);
        repeat (2) @(negedge clk);
        do_req(1'b1, 32'h0, 2'd0, 32'h00000003, rd, csd, rb, da);
        clr_mon();
        do_req(1'b0, 32'h0, 2'd0, 32'h0, rd, csd, rb, da);
        chk(mon_bits == 8, "R9", "cleared by cs change", 64'(mon_bits), 64'(8));

        // R8: a later 0x0B does not replace an earlier 0x03
        cfg_ctrl = mk_ctrl(8'h00, 2'd3, 1'b0, 3'd2, 1'b1);
        repeat (2) @(negedge clk);
        cfg_ctrl = mk_ctrl(8'h00, 2'd3, 1'b0, 3'd2, 1'b0);
        repeat (2) @(negedge clk);
        do_req(1'b1, 32'h0, 2'd0, 32'h00000003, rd, csd, rb, da);
        do_req(1'b1, 32'h0, 2'd0, 32'h0000000B, rd, csd, rb, da);
        clr_mon();
        do_req(1'b0, 32'h0, 2'd0, 32'h0, rd, csd, rb, da);
        chk(mon_bits == 8, "R8", "first byte wins", 64'(mon_bits), 64'(8));

        // R4: fast opcode with a zero dummy count goes straight to data
        cfg_ctrl = mk_ctrl(8'h00, 2'd3, 1'b0, 3'd0, 1'b1);
        repeat (2) @(negedge clk);
        cfg_ctrl = mk_ctrl(8'h00, 2'd3, 1'b0, 3'd0, 1'b0);
        repeat (2) @(negedge clk);
        do_req(1'b1, 32'h0, 2'd0, 32'h0000000B, rd, csd, rb, da);
        clr_mon();
        do_req(1'b0, 32'h0, 2'd0, 32'h0, rd, csd, rb, da);
        chk(mon_bits == 8, "R4", "zero dummy count", 64'(mon_bits), 64'(8));

        // R4: count 7 (bit 14 high) in user mode gives 56 dummy clocks
        cfg_ctrl = mk_ctrl(8'h00, 2'd3, 1'b0, 3'd7, 1'b1);
        repeat (2) @(negedge clk);
        cfg_ctrl = mk_ctrl(8'h00, 2'd3, 1'b0, 3'd7, 1'b0);
        repeat (2) @(negedge clk);
        do_req(1'b1, 32'h0, 2'd0, 32'h0000000B, rd, csd, rb, da);
        clr_mon();
        do_req(1'b0, 32'h0, 2'd0, 32'h0, rd, csd, rb, da);
        chk(mon_bits == 64, "R4", "maximum dummy count", 64'(mon_bits), 64'(64));
        chk(rd == {24'h0, pat(7)}, "R4", "data after max dummy", 64'(rd), 64'({24'h0, pat(7)}));

        cfg_ctrl = 32'h0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule